// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block sits on a stereo stream of signed 16-bit PCM samples and scales each sample by a gain taken from an 8-bit volume code. The code scale is logarithmic at 0.375 dB per step, and code zero is a hard mute. In automatic mode the engine owns the code. After an external limiter reports an event, it holds the gain for a programmable number of clean samples. It then raises the code in programmable steps toward a reference code. Each step waits for a zero crossing of the signal, or for a sample-count timeout if no crossing arrives.

In manual mode the gain comes straight from two per-channel code inputs. A link control lets the left code drive both channels. The code in use for the left (or shared) channel is always visible on an output port. The engine itself has three states:

- ST_MANUAL: follows the manual codes.
- ST_WAIT: counts clean samples.
- ST_ZC_PEND: holds a computed step until a crossing or the timeout.

The transitions are:

- ST_MANUAL to ST_WAIT on auto enable.
- ST_WAIT to ST_ZC_PEND when the waiting period completes with the code below the reference.
- ST_ZC_PEND to ST_WAIT on a crossing, a timeout or a limiter event.
- Any state to ST_MANUAL when auto enable drops.

Top module: `alc_gain_engine`

## Requirements
- R1: After reset, out_l and out_r are 0 and out_valid is 0.
- R2: Gain is exactly 2^n at code 0x91+16n: 0x91 is unity, 0x81 is x0.5, 0xA1 is x2 and 0xF1 is x64. 0x01 is 2^-9. Codes above 0xF1 act as 0xF1, and code 0x00 forces the output to 0.
- R3: The scaled product is rounded half toward plus infinity, then saturated to the range -32768..32767.
- R4: Each sample pair accepted with smp_valid appears on out_l/out_r with out_valid high in the following cycle only.
- R5: In manual mode with link=1, both channels use man_l. With link=0, the left channel uses man_l and the right uses man_r.
- R6: vol_code shows the code applied to the left channel: man_l in manual mode, the engine's own code in automatic mode.
- R7: A rise is scheduled only after 128<<wait_sel consecutive samples in which both |in_l| and |in_r| are at most thr and limit_evt is low. An over-threshold sample or a limit_evt restarts the count.
- R8: A rise adds step_sel+1 codes but never passes the reference (ref_code, capped at 0xF1). At or above the reference there is no rise.
- R9: A scheduled rise is applied on the first sample whose bit 15 differs from the previous sample of the same channel (either channel). If no such sample arrives, it is applied on the (128<<tmo_sel)-th pending sample.
- R10: A limit_evt while a rise is pending cancels it and restarts the waiting count.
- R11: On entering automatic mode the engine's code starts from the current man_l value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Stereo sample pair strobe |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| limit_evt | input | 1 | Limiter event pulse |
| auto_en | input | 1 | 1 = automatic recovery, 0 = manual |
| thr | input | 16 | Overload magnitude threshold for the waiting count |
| wait_sel | input | 2 | Waiting period select, 128<<wait_sel samples |
| tmo_sel | input | 2 | Zero-crossing timeout select, 128<<tmo_sel samples |
| step_sel | input | 2 | Rise step, step_sel+1 codes |
| ref_code | input | 8 | Reference code for recovery |
| man_l | input | 8 | Manual left code |
| man_r | input | 8 | Manual right code |
| link | input | 1 | 1 = man_l drives both channels in manual mode |
| out_l | output | 16 | Scaled left sample |
| out_r | output | 16 | Scaled right sample |
| out_valid | output | 1 | Output strobe |
| vol_code | output | 8 | Code in use for the left channel |

## Verification
The hardest case to reach from the ports is the difference between a waiting count that was truly restarted and one that merely kept running. Either way the code does not move until a zero crossing arrives. The stimulus therefore places one over-threshold sample inside the waiting period and times a sign change to land on the exact sample that completes the restarted count. A correct engine only schedules the step on that sample, while a count that was not restarted would apply the step there. The timeout path is reached the same way, with long runs of same-sign samples that never cross zero.

// File: rtl/alc_pkg.sv
package alc_pkg;
    localparam int SMP_W      = 16;
    localparam int CODE_W     = 8;
    localparam int MANT_W     = 16;
    localparam int MANT_FRAC  = 15;
    localparam int FRAC_STEPS = 16;
    localparam int OCT_UNITY  = 10;
    localparam logic [CODE_W-1:0] CODE_UNITY = 8'h91;
    localparam logic [CODE_W-1:0] CODE_TOP   = 8'hF1;
    localparam int IDX_OFS = FRAC_STEPS * OCT_UNITY - int'(CODE_UNITY);

    typedef enum logic [1:0] {
        ST_MANUAL  = 2'd0,
        ST_WAIT    = 2'd1,
        ST_ZC_PEND = 2'd2
    } alc_state_e;

    // 2^(f/16) in Q1.15
    function automatic logic [MANT_W-1:0] mant_lut(input logic [3:0] f);
        logic [MANT_W-1:0] m;
        unique case (f)
            4'd0:  m = 16'd32768;
            4'd1:  m = 16'd34219;
            4'd2:  m = 16'd35734;
            4'd3:  m = 16'd37316;
            4'd4:  m = 16'd38968;
            4'd5:  m = 16'd40693;
            4'd6:  m = 16'd42495;
            4'd7:  m = 16'd44376;
            4'd8:  m = 16'd46341;
            4'd9:  m = 16'd48393;
            4'd10: m = 16'd50535;
            4'd11: m = 16'd52773;
            4'd12: m = 16'd55109;
            4'd13: m = 16'd57549;
            4'd14: m = 16'd60097;
            default: m = 16'd62757;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/alc_gain_mult.sv
module alc_gain_mult
    import alc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [CODE_W-1:0]        code,
    input  logic signed [SMP_W-1:0]  din,
    output logic signed [SMP_W-1:0]  dout,
    output logic                     dout_valid
);
    localparam int PROD_W = SMP_W + MANT_W + 2;
    localparam logic signed [PROD_W-1:0] SMAX =
        {{(PROD_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SMIN = ~SMAX;

    logic [CODE_W-1:0]        c_sat;
    logic [CODE_W:0]          idx;
    logic [4:0]               oct;
    logic [3:0]               frac;
    logic [5:0]               shamt;
    logic signed [PROD_W-1:0] prod, bias, rnd, shf;
    logic signed [SMP_W-1:0]  y_n;

    always_comb begin
        c_sat = (code > CODE_TOP) ? CODE_TOP : code;
        idx   = {1'b0, c_sat} + (CODE_W+1)'(IDX_OFS);
        oct   = idx[8:4];
        frac  = idx[3:0];
        shamt = 6'(MANT_FRAC + OCT_UNITY) - {1'b0, oct};
        prod  = PROD_W'($signed(din)) * PROD_W'($signed({1'b0, mant_lut(frac)}));
        bias  = $signed(PROD_W'(1) << (shamt - 6'd1));
        rnd   = prod + bias;
        shf   = rnd >>> shamt;
        if (code == '0)
            y_n = '0;
        else if (shf > SMAX)
            y_n = SMAX[SMP_W-1:0];
        else if (shf < SMIN)
            y_n = SMIN[SMP_W-1:0];
        else
            y_n = shf[SMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= in_valid;
            if (in_valid)
                dout <= y_n;
        end
    end

    // R2
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code == '0) |=> (dout == '0));
endmodule

// File: rtl/alc_recovery_fsm.sv
module alc_recovery_fsm
    import alc_pkg::*;
#(
    parameter int BASE_WAIT = 128,
    parameter int BASE_TMO  = 128
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              smp_valid,
    input  logic              overload,
    input  logic              zc,
    input  logic              limit_evt,
    input  logic [1:0]        wait_sel,
    input  logic [1:0]        tmo_sel,
    input  logic [1:0]        step_sel,
    input  logic [CODE_W-1:0] ref_code,
    input  logic [CODE_W-1:0] man_code,
    output logic [CODE_W-1:0] vol_q,
    output alc_state_e        st_q
);
    localparam int LEN_MAX = ((BASE_WAIT > BASE_TMO) ? BASE_WAIT : BASE_TMO) * 8;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    alc_state_e        st_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, tcnt_q, tcnt_n;
    logic [CNT_W-1:0]  wait_len, tmo_len;
    logic [CODE_W-1:0] vol_n, ref_c, target;
    logic [CODE_W:0]   raised;

    always_comb begin
        wait_len = CNT_W'(BASE_WAIT) << wait_sel;
        tmo_len  = CNT_W'(BASE_TMO) << tmo_sel;
        ref_c    = (ref_code > CODE_TOP) ? CODE_TOP : ref_code;
        raised   = {1'b0, vol_q} + {7'd0, step_sel} + 9'd1;
        target   = (raised >= {1'b0, ref_c}) ? ref_c : raised[CODE_W-1:0];
    end

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        tcnt_n = tcnt_q;
        vol_n  = vol_q;
        if (!auto_en) begin
            st_n   = ST_MANUAL;
            cnt_n  = '0;
            tcnt_n = '0;
            if (st_q == ST_MANUAL)
                vol_n = man_code;
        end else begin
            unique case (st_q)
                ST_MANUAL: begin
                    st_n  = ST_WAIT;
                    cnt_n = '0;
                end
                ST_WAIT: begin
                    if (limit_evt)
                        cnt_n = '0;
                    else if (smp_valid) begin
                        if (overload)
                            cnt_n = '0;
                        else if (cnt_q >= wait_len - 1'b1) begin
                            cnt_n = '0;
                            if (vol_q < ref_c) begin
                                st_n   = ST_ZC_PEND;
                                tcnt_n = '0;
                            end
                        end else
                            cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_ZC_PEND: begin
                    if (limit_evt) begin
                        st_n  = ST_WAIT;
                        cnt_n = '0;
                    end else if (smp_valid) begin
                        if (zc || tcnt_q >= tmo_len - 1'b1) begin
                            if (vol_q < ref_c)
                                vol_n = target;
                            st_n  = ST_WAIT;
                            cnt_n = '0;
                        end else
                            tcnt_n = tcnt_q + 1'b1;
                    end
                end
                default: st_n = ST_MANUAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_MANUAL;
            cnt_q  <= '0;
            tcnt_q <= '0;
            vol_q  <= CODE_UNITY;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            tcnt_q <= tcnt_n;
            vol_q  <= vol_n;
        end
    end

    // R8
    step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_ZC_PEND && st_q == ST_WAIT && vol_q != $past(vol_q))
        |-> (vol_q <= $past(ref_c)));
    // R8
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_ZC_PEND && vol_q != $past(vol_q))
        |-> (vol_q > $past(vol_q) && (vol_q - $past(vol_q)) <= 8'd4));
    // R9
    change_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_MANUAL && $past(st_q) != ST_MANUAL && vol_q != $past(vol_q))
        |-> $past(smp_valid));
    // R7
    pend_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ZC_PEND && $past(st_q) != ST_ZC_PEND)
        |-> ($past(st_q) == ST_WAIT && $past(smp_valid)));
endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
    import alc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [SMP_W-1:0]  in_l,
    input  logic signed [SMP_W-1:0]  in_r,
    input  logic                     limit_evt,
    input  logic                     auto_en,
    input  logic [SMP_W-1:0]         thr,
    input  logic [1:0]               wait_sel,
    input  logic [1:0]               tmo_sel,
    input  logic [1:0]               step_sel,
    input  logic [CODE_W-1:0]        ref_code,
    input  logic [CODE_W-1:0]        man_l,
    input  logic [CODE_W-1:0]        man_r,
    input  logic                     link,
    output logic signed [SMP_W-1:0]  out_l,
    output logic signed [SMP_W-1:0]  out_r,
    output logic                     out_valid,
    output logic [CODE_W-1:0]        vol_code
);
    localparam int NCH = 2;

    alc_state_e              st;
    logic [CODE_W-1:0]       vol;
    logic signed [SMP_W-1:0] din  [NCH];
    logic signed [SMP_W-1:0] dout [NCH];
    logic [CODE_W-1:0]       code_ch [NCH];
    logic [NCH-1:0]          vld, ovl, sgn_q, flip;
    logic                    zc;

    assign din[0] = in_l;
    assign din[1] = in_r;

    always_comb begin
        if (st == ST_MANUAL) begin
            code_ch[0] = man_l;
            code_ch[1] = link ? man_l : man_r;
        end else begin
            code_ch[0] = vol;
            code_ch[1] = vol;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [SMP_W:0] mag;
        assign mag      = din[ch][SMP_W-1] ? (~{1'b1, din[ch]} + 1'b1) : {1'b0, din[ch]};
        assign ovl[ch]  = mag > {1'b0, thr};
        assign flip[ch] = din[ch][SMP_W-1] ^ sgn_q[ch];

        alc_gain_mult u_mult (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (smp_valid),
            .code       (code_ch[ch]),
            .din        (din[ch]),
            .dout       (dout[ch]),
            .dout_valid (vld[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sgn_q <= '0;
        else if (smp_valid)
            sgn_q <= {in_r[SMP_W-1], in_l[SMP_W-1]};
    end

    assign zc = |flip;

    alc_recovery_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .smp_valid (smp_valid),
        .overload  (|ovl),
        .zc        (zc),
        .limit_evt (limit_evt),
        .wait_sel  (wait_sel),
        .tmo_sel   (tmo_sel),
        .step_sel  (step_sel),
        .ref_code  (ref_code),
        .man_code  (man_l),
        .vol_q     (vol),
        .st_q      (st)
    );

    assign out_l     = dout[0];
    assign out_r     = dout[1];
    assign out_valid = &vld;
    assign vol_code  = code_ch[0];
endmodule

// File: tb/alc_gain_engine_tb.sv
`timescale 1ns/1ps
module alc_gain_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [15:0] in_l = '0, in_r = '0;
    logic limit_evt = 1'b0, auto_en = 1'b0, link = 1'b1;
    logic [15:0] thr = 16'd1000;
    logic [1:0] wait_sel = 2'd0, tmo_sel = 2'd0, step_sel = 2'd1;
    logic [7:0] ref_code = 8'h95, man_l = 8'h91, man_r = 8'h91;
    logic signed [15:0] out_l, out_r;
    logic out_valid;
    logic [7:0] vol_code;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alc_gain_engine u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .in_l(in_l), .in_r(in_r),
        .limit_evt(limit_evt), .auto_en(auto_en), .thr(thr), .wait_sel(wait_sel),
        .tmo_sel(tmo_sel), .step_sel(step_sel), .ref_code(ref_code), .man_l(man_l),
        .man_r(man_r), .link(link), .out_l(out_l), .out_r(out_r),
        .out_valid(out_valid), .vol_code(vol_code)
    );

    // fields: man_l, man_r, link, in_l, in_r, exp_l, exp_r
    localparam int NV = 9;
    localparam logic [80:0] VECS [NV] = '{
        {8'h91, 8'h91, 1'b1,  16'sd1000,  -16'sd1000, 16'sd1000,  -16'sd1000},  // R2 unity
        {8'h81, 8'h81, 1'b1,  16'sd3,     -16'sd3,    16'sd2,     -16'sd1},     // R3 rounding
        {8'hA1, 8'hA1, 1'b1,  16'sd1000,  -16'sd20000, 16'sd2000, -16'sd32768}, // R3 low sat
        {8'hF1, 8'hF1, 1'b1,  16'sd100,   16'sd600,   16'sd6400,  16'sd32767},  // R3 high sat
        {8'hFF, 8'hFF, 1'b1,  16'sd100,   -16'sd100,  16'sd6400,  -16'sd6400},  // R2 clamp
        {8'h00, 8'h00, 1'b1,  16'sd12345, -16'sd12345, 16'sd0,    16'sd0},      // R2 mute
        {8'h91, 8'h81, 1'b0,  16'sd500,   16'sd500,   16'sd500,   16'sd250},    // R5 split
        {8'h81, 8'hA1, 1'b1,  16'sd500,   16'sd500,   16'sd250,   16'sd250},    // R5 linked
        {8'h01, 8'h01, 1'b1,  16'sd32767, -16'sd32768, 16'sd64,   -16'sd64}     // R2 bottom
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic signed [15:0] l, input logic signed [15:0] r);
        @(negedge clk);
        in_l = l; in_r = r; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_n(input int n, input logic signed [15:0] v);
        for (int k = 0; k < n; k++) send(v, v);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 out_l", out_l, 0);
        chk("R1 out_r", out_r, 0);
        chk("R1 out_valid", out_valid, 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] ml, mr;
            logic lk;
            logic signed [15:0] il, ir, el, er;
            {ml, mr, lk, il, ir, el, er} = VECS[i];
            man_l = ml; man_r = mr; link = lk;
            send(il, ir);
            chk($sformatf("R2/R3/R5 vec%0d left", i), out_l, el);
            chk($sformatf("R2/R3/R5 vec%0d right", i), out_r, er);
        end

        // R4 one-cycle strobe
        send(16'sd7, 16'sd7);
        chk("R4 valid high", out_valid, 1);
        @(negedge clk);
        chk("R4 valid low", out_valid, 0);

        // R6 manual readback
        man_l = 8'h81;
        @(negedge clk);
        chk("R6 manual vol_code", vol_code, 8'h81);

        // automatic mode
        man_l = 8'h8F; link = 1'b1; ref_code = 8'h95; step_sel = 2'd1;
        @(negedge clk);
        auto_en = 1'b1;
        @(negedge clk);
        chk("R11 entry code", vol_code, 8'h8F);

        send_n(127, 16'sd10);
        chk("R7 before wait end", vol_code, 8'h8F);
        send(16'sd10, 16'sd10);
        chk("R9 pending no zc", vol_code, 8'h8F);
        send(-16'sd10, -16'sd10);
        chk("R9 applied at zc", vol_code, 8'h91);

        ref_code = 8'h92;
        send(16'sd10, 16'sd10);
        chk("R6 auto path out", out_l, 10);
        send_n(99, 16'sd10);
        send(16'sd2000, 16'sd10);
        send_n(127, 16'sd10);
        send(-16'sd10, -16'sd10);
        chk("R7 count restarted by overload", vol_code, 8'h91);
        send(16'sd10, 16'sd10);
        chk("R8 capped at reference", vol_code, 8'h92);

        send_n(128, 16'sd10);
        send(-16'sd10, -16'sd10);
        chk("R8 no rise at reference", vol_code, 8'h92);
        ref_code = 8'h93;
        send_n(127, -16'sd10);
        send(16'sd10, 16'sd10);
        chk("R8 partial step capped", vol_code, 8'h93);

        ref_code = 8'hA0; step_sel = 2'd3;
        send_n(128, 16'sd10);
        send_n(127, 16'sd10);
        chk("R9 before timeout", vol_code, 8'h93);
        send(16'sd10, 16'sd10);
        chk("R9 timeout apply", vol_code, 8'h97);

        send_n(128, 16'sd10);
        @(negedge clk);
        limit_evt = 1'b1;
        @(negedge clk);
        limit_evt = 1'b0;
        send(-16'sd10, -16'sd10);
        chk("R10 pending cancelled", vol_code, 8'h97);
        send_n(127, -16'sd10);
        send(16'sd10, 16'sd10);
        chk("R10 resumes after new wait", vol_code, 8'h9B);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule